// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block generates one pulse-width modulated output from an 8-bit period setting and an 8-bit duty setting. Each setting has two copies. A buffer copy takes every bus write and is what a read returns. An active copy drives the waveform. While the channel runs, the active copies reload from the buffers only when the counter finishes a period, or on the cycle the channel is switched on. As a result, every emitted period is built wholly from one pair of settings. While the channel is stopped, a write reaches both copies at once.

The counter advances only on cycles with the tick input high, so an external prescaler sets the time base. In edge mode the counter runs 0 up to period minus one and wraps. In symmetric mode it runs 0 up to the period value and then back down to 1, so one output period spans twice the programmed value in ticks. A polarity input picks the level that each period starts with (the active level). A stopped channel drives the inactive level.

Top module: `dbpwm_channel`

## Requirements
- R1: After reset both buffer and active copies are 0, a read at either address returns 0, and a stopped channel drives the inactive level.
- R2: A read returns the buffer copy for the selected address (address 0 = period, address 1 = duty), that is, the last value written, even while the active copy still holds an older value.
- R3: While `chan_en` is low, a write updates the active copy in the same clock edge, so the first period after enabling uses the written values.
- R4: While `chan_en` is high, a write only updates the buffer. The active copy changes only at the end of a period or on the first enabled cycle, so a running period is never altered.
- R5: Edge mode (`center_mode` = 0): one period lasts P ticks and the output is active for the first D ticks (counter values below D).
- R6: Symmetric mode (`center_mode` = 1): one period lasts 2*P ticks and the output is active for 2*D ticks, centred on counter value 0.
- R7: The counter holds its value on every cycle where `tick` is low, which stretches the waveform in time without changing its shape.
- R8: `start_high` = 1 makes the active level high, and `start_high` = 0 makes it low.
- R9: An active period of 0 holds the output at the active level while the channel runs.
- R10: An active duty at or above a non-zero active period holds the output at the active level.
- R11: An active duty of 0 with a non-zero period holds the output at the inactive level.
- R12: While `chan_en` is low the output sits at the inactive level and the counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 period, 1 duty |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Buffer copy of the selected register |
| chan_en | input | 1 | Channel run enable |
| tick | input | 1 | Prescaled count enable |
| center_mode | input | 1 | 0 edge counting, 1 symmetric counting |
| start_high | input | 1 | Active level of the output |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check on every cycle the following: the counter holds when no tick arrives, the counter stays within the active period, the active copies change only on a load event or a stopped-channel write, a stopped-channel write lands in the active copy, and the forced levels for a stopped channel and a zero period. Other properties span a whole period and appear only in the bench scenarios: the high-time and period counts in both counting modes, the deferral of a running write to the next period boundary, the stretching under a sparse tick, and the polarity swap. The bench's behavioural model is compared against the output and the read data on every clock.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
   typedef enum logic {
      SEL_PERIOD = 1'b0,
      SEL_DUTY   = 1'b1
   } dbpwm_sel_e;

   localparam int NUM_SETTINGS = 2;
endpackage

// File: rtl/dbpwm_dbreg.sv
module dbpwm_dbreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         direct,
   input  logic         load,
   output logic [W-1:0] buf_q,
   output logic [W-1:0] act_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         act_q <= '0;
      end else begin
         if (wr_en) buf_q <= wr_data;
         if (wr_en && direct)  act_q <= wr_data;
         else if (load)        act_q <= buf_q;
      end
   end

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(wr_en && direct)) |=> $stable(act_q)); // R4
   AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && direct) |=> (act_q == $past(wr_data))); // R3
endmodule

// File: rtl/dbpwm_counter.sv
module dbpwm_counter #(
   parameter int W          = 8,
   parameter bit HAS_CENTER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic         center,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt_q,
   output logic         up_q,
   output logic         eop
);
   localparam logic [W-1:0] ONE = W'(1);

   logic         center_eff;
   logic [W-1:0] cnt_d;
   logic         up_d;

   generate
      if (HAS_CENTER) begin : g_center
         assign center_eff = center;
      end else begin : g_edge_only
         assign center_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      cnt_d = cnt_q;
      up_d  = up_q;
      eop   = 1'b0;
      if (!run) begin
         cnt_d = '0;
         up_d  = 1'b1;
      end else if (tick) begin
         if (period == '0) begin
            cnt_d = '0;
            up_d  = 1'b1;
            eop   = 1'b1;
         end else if (!center_eff) begin
            up_d = 1'b1;
            if (cnt_q >= period - ONE) begin
               cnt_d = '0;
               eop   = 1'b1;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else if (up_q) begin
            if (cnt_q >= period) begin
               if (period == ONE) begin
                  cnt_d = '0;
                  eop   = 1'b1;
               end else begin
                  cnt_d = period - ONE;
                  up_d  = 1'b0;
               end
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else begin
            if (cnt_q <= ONE) begin
               cnt_d = '0;
               up_d  = 1'b1;
               eop   = 1'b1;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
      end
   end

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q)); // R7
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period != '0) |-> (cnt_q <= period)); // R6
endmodule

// File: rtl/dbpwm_outgen.sv
module dbpwm_outgen #(
   parameter int W = 8
) (
   input  logic         run,
   input  logic         up,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] period,
   input  logic [W-1:0] duty,
   input  logic         start_high,
   output logic         pwm
);
   logic in_window;
   logic active;

   always_comb begin
      in_window = up ? (cnt < duty) : (cnt <= duty);
      active    = run && ((period == '0) || (duty >= period) || in_window);
      pwm       = active ? start_high : ~start_high;
   end
endmodule

// File: rtl/dbpwm_channel.sv
module dbpwm_channel
   import dbpwm_pkg::*;
#(
   parameter int W          = 8,
   parameter bit HAS_CENTER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_addr,
   input  logic         reg_we,
   input  logic [7:0]   reg_wdata,
   output logic [7:0]   reg_rdata,
   input  logic         chan_en,
   input  logic         tick,
   input  logic         center_mode,
   input  logic         start_high,
   output logic         pwm_out
);
   localparam int DW = 8;

   generate
      if (W != DW) begin : g_bad_width
         $error("dbpwm_channel: W must match the 8-bit bus");
      end
   endgenerate

   logic [W-1:0] buf_q [NUM_SETTINGS];
   logic [W-1:0] act_q [NUM_SETTINGS];
   logic         en_q;
   logic         eop;
   logic         load;
   logic [W-1:0] cnt;
   logic         up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= chan_en;
   end

   assign load = eop | (chan_en & ~en_q);

   generate
      for (genvar i = 0; i < NUM_SETTINGS; i++) begin : g_set
         dbpwm_dbreg #(.W(W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && (reg_addr == i[0])),
            .wr_data (reg_wdata),
            .direct  (~chan_en),
            .load    (load),
            .buf_q   (buf_q[i]),
            .act_q   (act_q[i])
         );
      end
   endgenerate

   assign reg_rdata = (dbpwm_sel_e'(reg_addr) == SEL_PERIOD) ? buf_q[SEL_PERIOD] : buf_q[SEL_DUTY];

   dbpwm_counter #(.W(W), .HAS_CENTER(HAS_CENTER)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (chan_en),
      .tick   (tick),
      .center (center_mode),
      .period (act_q[SEL_PERIOD]),
      .cnt_q  (cnt),
      .up_q   (up),
      .eop    (eop)
   );

   dbpwm_outgen #(.W(W)) u_out (
      .run        (chan_en),
      .up         (up),
      .cnt        (cnt),
      .period     (act_q[SEL_PERIOD]),
      .duty       (act_q[SEL_DUTY]),
      .start_high (start_high),
      .pwm        (pwm_out)
   );

   AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> (pwm_out == ~start_high)); // R12
   AST_ZERO_PERIOD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && act_q[SEL_PERIOD] == '0) |-> (pwm_out == start_high)); // R9
   AST_DUTY_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && act_q[SEL_PERIOD] != '0 && act_q[SEL_DUTY] == '0) |-> (pwm_out == ~start_high)); // R11
endmodule

// File: tb/dbpwm_channel_tb.sv
module dbpwm_channel_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_addr = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       chan_en = 1'b0;
   logic       tick = 1'b1;
   logic       center_mode = 1'b0;
   logic       start_high = 1'b1;
   logic       pwm_out;
   logic       tick_sparse = 1'b0;

   int errors = 0;
   int checks = 0;
   int hi_cnt = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_buf [2];
   int m_act [2];
   int m_cnt;
   bit m_up;
   bit m_en_q;

   always #4 clk = ~clk;

   dbpwm_channel u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_en(chan_en),
      .tick(tick), .center_mode(center_mode), .start_high(start_high),
      .pwm_out(pwm_out)
   );

   always @(negedge clk) tick <= tick_sparse ? ~tick : 1'b1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_buf[0] = 0; m_buf[1] = 0; m_act[0] = 0; m_act[1] = 0;
         m_cnt = 0; m_up = 1'b1; m_en_q = 1'b0;
      end else begin
         int p;
         int ncnt;
         bit nup;
         bit wrap;
         p = m_act[0]; ncnt = m_cnt; nup = m_up; wrap = 1'b0;
         if (!chan_en) begin
            ncnt = 0; nup = 1'b1;
         end else if (tick) begin
            if (p == 0) begin ncnt = 0; nup = 1'b1; wrap = 1'b1; end
            else if (!center_mode) begin
               nup = 1'b1;
               if (m_cnt >= p - 1) begin ncnt = 0; wrap = 1'b1; end else ncnt = m_cnt + 1;
            end else if (m_up) begin
               if (m_cnt >= p) begin
                  if (p == 1) begin ncnt = 0; wrap = 1'b1; end
                  else begin ncnt = p - 1; nup = 1'b0; end
               end else ncnt = m_cnt + 1;
            end else begin
               if (m_cnt <= 1) begin ncnt = 0; nup = 1'b1; wrap = 1'b1; end
               else ncnt = m_cnt - 1;
            end
         end
         for (int i = 0; i < 2; i++) begin
            if (reg_we && !chan_en && int'(reg_addr) == i) m_act[i] = int'(reg_wdata);
            else if (wrap || (chan_en && !m_en_q)) m_act[i] = m_buf[i];
         end
         if (reg_we) m_buf[int'(reg_addr)] = int'(reg_wdata);
         m_cnt = ncnt; m_up = nup; m_en_q = chan_en;
      end
   end

   function automatic bit model_out();
      bit act;
      bit win;
      win = m_up ? (m_cnt < m_act[1]) : (m_cnt <= m_act[1]);
      act = chan_en && (m_act[0] == 0 || m_act[1] >= m_act[0] || win);
      return act ? start_high : !start_high;
   endfunction

   always begin
      @(negedge clk);
      #3;
      if (rst_n && !done) begin
         if (pwm_out) hi_cnt++;
         checks++;
         if (pwm_out !== model_out()) begin
            errors++;
            $display("FAIL R5 per-cycle output: got %0b expected %0b", pwm_out, model_out());
         end
         checks++;
         if (int'(reg_rdata) != m_buf[int'(reg_addr)]) begin
            errors++;
            $display("FAIL R2 per-cycle readback: got %0d expected %0d", reg_rdata, m_buf[int'(reg_addr)]);
         end
      end
   end

   task automatic tick_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_reg(bit a, int v);
      reg_addr = a; reg_wdata = 8'(v); reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic check(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic window(string tag, int n, int exp);
      int h0;
      h0 = hi_cnt;
      tick_n(n);
      check(tag, hi_cnt - h0, exp);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick_n(5);
      rst_n = 1'b1;
      tick_n(1);
      #3;
      check("R1 reset period readback", int'(reg_rdata), 0);
      check("R1 reset output idle", int'(pwm_out), 0);
      reg_addr = 1'b1;
      #1;
      check("R1 reset duty readback", int'(reg_rdata), 0);
      @(negedge clk);

      // stopped-channel writes, then buffered write on the enabling cycle
      write_reg(1'b0, 10);
      write_reg(1'b1, 3);
      chan_en = 1'b1;
      begin
         int h0;
         h0 = hi_cnt;
         write_reg(1'b1, 7);
         tick_n(9);
         check("R3 R4 first period keeps old duty", hi_cnt - h0, 3);
         check("R2 readback shows buffered duty", int'(reg_rdata), 7);
      end
      window("R4 next period uses new duty", 10, 7);

      write_reg(1'b1, 4);
      tick_n(25);
      window("R5 edge mode P=10 D=4", 20, 8);

      tick_sparse = 1'b1;
      tick_n(30);
      window("R7 half-rate tick stretches waveform", 40, 16);
      tick_sparse = 1'b0;

      center_mode = 1'b1;
      write_reg(1'b0, 5);
      write_reg(1'b1, 2);
      tick_n(30);
      window("R6 symmetric mode P=5 D=2", 20, 8);

      start_high = 1'b0;
      tick_n(2);
      window("R8 low active level", 20, 12);
      start_high = 1'b1;

      write_reg(1'b1, 9);
      tick_n(30);
      window("R10 duty above period", 20, 20);

      write_reg(1'b1, 2);
      write_reg(1'b0, 0);
      tick_n(30);
      window("R9 zero period", 20, 20);

      write_reg(1'b0, 8);
      write_reg(1'b1, 0);
      tick_n(40);
      window("R11 zero duty", 16, 0);

      chan_en = 1'b0;
      window("R12 stopped output idle high-active", 10, 0);
      start_high = 1'b0;
      window("R12 stopped output idle low-active", 10, 10);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule